// File: doc/BRIEF.md
# Split-Phase Hardware Barrier Synchronizer

This block lets a group of processors meet at a barrier without making each one wait the moment it arrives. Arrival and the blocking wait are two separate events. A processor gives a one-cycle enter pulse when it reaches the start of its barrier region. It then keeps running the instructions of that region. When it reaches the end of the region it raises an exit request. It is stalled at that point only if some participating processor has not yet entered its own region.

A mask register chooses which processors take part. The block keeps one sticky ready flag per processor. When every masked processor is ready, the barrier fires. Firing clears all ready flags and sets a synced flag for every participant. A synced flag grants the next exit request at once and is consumed by that exit. A processor that is not in the mask counts as always ready, and its exit requests are granted at once. An enter pulse that arrives before the processor's previous episode has been consumed does not count. Instead it raises a sticky error flag for that processor.

Top module: `split_barrier_sync`

## Requirements
- R1: A synchronous active-high reset clears every ready, synced and error flag. After reset, every enterErr bit is 0, and an exit request from a participant is stalled.
- R2: An enter pulse from a participant is remembered. That processor is not stalled unless it raises exitReq. An exit request raised before every participant has entered gives stall=1 and goAhead=0 for that processor.
- R3: Suppose the clock edge that samples an enter pulse leaves every participant either ready or freshly entered. Then the barrier fires at that edge. From the following cycle, every participant with exitReq high sees goAhead=1 and stall=0.
- R4: Once the barrier has fired, a participant's exit request is granted in the same cycle it is raised (goAhead is combinational from exitReq).
- R5: The clock edge that samples exitReq=1 together with goAhead=1 consumes that participant's synced flag. After that, a new exit request from it stalls until the next firing.
- R6: A processor whose mask bit is 0 is treated as always ready. Its exitReq is answered with goAhead=1 and never with stall. Its enter pulses are ignored and never set its error bit.
- R7: If a participant pulses enter while its ready or synced flag is still set, the pulse does not count toward the barrier and its enterErr bit goes to 1.
- R8: Firing clears every ready flag. The next episode needs a fresh enter from every participant.
- R9: A mask write (maskWe=1) takes effect at the next clock edge. During the write cycle the old mask still governs stall and goAhead. After reset the mask is all ones.
- R10: An enterErr bit, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| maskWe | input | 1 | Load maskData into the participation mask |
| maskData | input | NUM_PROC | New participation mask, bit i for processor i |
| enterPulse | input | NUM_PROC | One-cycle pulse when processor i enters its barrier region |
| exitReq | input | NUM_PROC | Processor i is at the end of its region, held until goAhead |
| goAhead | output | NUM_PROC | Processor i may leave its region this cycle |
| stall | output | NUM_PROC | Processor i must wait |
| enterErr | output | NUM_PROC | Sticky flag: processor i entered before consuming its previous episode |

## Verification
The bench sweeps every non-empty mask against every pattern of early enters, on a four-processor build. A design that counted non-participants, or fired on a subset of participants, would grant early exits that should stall. One that left ready flags set after firing would fire the next partial episode too early. Exits are held across a clock edge to show that synced flags are consumed: a design that kept them would let a second exit through without a new barrier. Directed cases cover double enters and enters while still synced, which must raise the error flag without advancing the barrier. They also check that error flags survive until reset, and that a mask write only takes effect after its edge.

// File: rtl/sbar_pkg.sv
package sbar_pkg;
  typedef struct packed {
    logic fire;      // every participant ready this edge
    logic maskLoad;  // write participation mask this edge
  } barStrobe_t;
endpackage

// File: rtl/sbar_datapath.sv
module sbar_datapath
  import sbar_pkg::*;
#(
  parameter int NUM_PROC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  barStrobe_t          strobe,
  input  logic [NUM_PROC-1:0] maskData,
  input  logic [NUM_PROC-1:0] acceptVec,
  input  logic [NUM_PROC-1:0] errSetVec,
  input  logic [NUM_PROC-1:0] consumeVec,
  output logic [NUM_PROC-1:0] maskReg,
  output logic [NUM_PROC-1:0] readyQ,
  output logic [NUM_PROC-1:0] syncedQ,
  output logic [NUM_PROC-1:0] errQ
);
  localparam logic [NUM_PROC-1:0] MASK_RESET = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg <= MASK_RESET;
      readyQ  <= '0;
      syncedQ <= '0;
      errQ    <= '0;
    end else begin
      if (strobe.maskLoad) maskReg <= maskData;
      readyQ  <= strobe.fire ? '0 : (readyQ | acceptVec);
      syncedQ <= (syncedQ & ~consumeVec) | (strobe.fire ? maskReg : '0);
      errQ    <= errQ | errSetVec;
    end
  end

  AST_FIRE_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    strobe.fire |=> (readyQ == '0)); // R8

  AST_FIRE_SETS_SYNC: assert property (@(posedge clk) disable iff (rst)
    strobe.fire |=> ((syncedQ & $past(maskReg)) == $past(maskReg))); // R3

  AST_SYNC_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
    ((syncedQ & ~$past(syncedQ)) != '0) |-> $past(strobe.fire)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (($past(errQ) & ~errQ) == '0)); // R10

  AST_READY_SYNC_EXCL: assert property (@(posedge clk) disable iff (rst)
    ((readyQ & syncedQ) == '0)); // R7
endmodule

// File: rtl/sbar_ctrl.sv
module sbar_ctrl
  import sbar_pkg::*;
#(
  parameter int NUM_PROC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                maskWe,
  input  logic [NUM_PROC-1:0] enterPulse,
  input  logic [NUM_PROC-1:0] exitReq,
  input  logic [NUM_PROC-1:0] maskReg,
  input  logic [NUM_PROC-1:0] readyQ,
  input  logic [NUM_PROC-1:0] syncedQ,
  output barStrobe_t          strobe,
  output logic [NUM_PROC-1:0] acceptVec,
  output logic [NUM_PROC-1:0] errSetVec,
  output logic [NUM_PROC-1:0] consumeVec,
  output logic [NUM_PROC-1:0] goAhead,
  output logic [NUM_PROC-1:0] stall
);
  logic [NUM_PROC-1:0] pendingEp;
  logic [NUM_PROC-1:0] readyNext;

  always_comb begin
    pendingEp  = readyQ | syncedQ;
    acceptVec  = enterPulse & maskReg & ~pendingEp;
    errSetVec  = enterPulse & maskReg & pendingEp;
    readyNext  = readyQ | acceptVec;
    strobe.fire     = (|maskReg) && (&(readyNext | ~maskReg));
    strobe.maskLoad = maskWe;
    goAhead    = exitReq & (syncedQ | ~maskReg);
    stall      = exitReq & ~goAhead;
    consumeVec = exitReq & syncedQ;
  end

  AST_STALL_ONLY_PARTICIPANT: assert property (@(posedge clk) disable iff (rst)
    ((stall & ~maskReg) == '0)); // R6

  AST_NO_ACCEPT_WHILE_SYNCED: assert property (@(posedge clk) disable iff (rst)
    ((acceptVec & syncedQ) == '0)); // R7
endmodule

// File: rtl/split_barrier_sync.sv
module split_barrier_sync
  import sbar_pkg::*;
#(
  parameter int NUM_PROC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                maskWe,
  input  logic [NUM_PROC-1:0] maskData,
  input  logic [NUM_PROC-1:0] enterPulse,
  input  logic [NUM_PROC-1:0] exitReq,
  output logic [NUM_PROC-1:0] goAhead,
  output logic [NUM_PROC-1:0] stall,
  output logic [NUM_PROC-1:0] enterErr
);
  barStrobe_t          strobe;
  logic [NUM_PROC-1:0] maskReg, readyQ, syncedQ;
  logic [NUM_PROC-1:0] acceptVec, errSetVec, consumeVec;

  sbar_ctrl #(.NUM_PROC(NUM_PROC)) ctrl_i (
    .clk(clk), .rst(rst), .maskWe(maskWe), .enterPulse(enterPulse),
    .exitReq(exitReq), .maskReg(maskReg), .readyQ(readyQ), .syncedQ(syncedQ),
    .strobe(strobe), .acceptVec(acceptVec), .errSetVec(errSetVec),
    .consumeVec(consumeVec), .goAhead(goAhead), .stall(stall)
  );

  sbar_datapath #(.NUM_PROC(NUM_PROC)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .maskData(maskData),
    .acceptVec(acceptVec), .errSetVec(errSetVec), .consumeVec(consumeVec),
    .maskReg(maskReg), .readyQ(readyQ), .syncedQ(syncedQ), .errQ(enterErr)
  );
endmodule

// File: tb/split_barrier_sync_tb_top.sv
module split_barrier_sync_tb_top;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic maskWe = 1'b0;
  logic [N-1:0] maskData = '0, enterPulse = '0, exitReq = '0;
  logic [N-1:0] goAhead, stall, enterErr;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_barrier_sync #(.NUM_PROC(N)) dut_i (
    .clk(clk), .rst(rst), .maskWe(maskWe), .maskData(maskData),
    .enterPulse(enterPulse), .exitReq(exitReq), .goAhead(goAhead),
    .stall(stall), .enterErr(enterErr)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // raise exit requests mid-cycle, sample, drop before the edge
  task automatic peek(input logic [N-1:0] req, output logic [N-1:0] g, output logic [N-1:0] s);
    exitReq = req;
    #1;
    g = goAhead;
    s = stall;
    exitReq = '0;
  endtask

  task automatic writeMask(input logic [N-1:0] m);
    maskWe = 1'b1; maskData = m; cyc(); maskWe = 1'b0;
  endtask

  task automatic enter(input logic [N-1:0] e);
    enterPulse = e; cyc(); enterPulse = '0;
  endtask

  task automatic consumeAll();
    exitReq = ALL; cyc(); exitReq = '0;
  endtask

  task automatic doReset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0; cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] g, s;
    cyc();
    doReset();

    // R1 / R9: reset state, mask all ones
    chk("R1 enterErr after reset", enterErr, '0);
    peek(ALL, g, s);
    chk("R1 stall after reset", s, ALL);
    chk("R9 reset mask all ones goAhead", g, '0);

    // R9: mask write seen only after its edge
    maskWe = 1'b1; maskData = 4'b0101;
    peek(ALL, g, s);
    chk("R9 old mask during write", s, ALL);
    cyc(); maskWe = 1'b0;
    peek(ALL, g, s);
    chk("R9 new mask after edge stall", s, 4'b0101);
    chk("R9 new mask after edge goAhead", g, 4'b1010);

    // R7: double enter and enter while synced
    writeMask(ALL);
    enter(4'b0001);
    enter(4'b0001);
    chk("R7 double enter sets error", enterErr, 4'b0001);
    enter(4'b1110);
    peek(ALL, g, s);
    chk("R7 first enter still counted fire", g, ALL);
    enter(4'b0010);
    chk("R7 enter while synced sets error", enterErr, 4'b0011);
    consumeAll();
    enter(4'b1101);
    peek(ALL, g, s);
    chk("R7 errored enter not counted", s, ALL);
    enter(4'b0010);
    peek(ALL, g, s);
    chk("R7 fire after proper enter", g, ALL);
    consumeAll();

    // R10: error flags persist until reset
    for (int k = 0; k < 20; k++) cyc();
    chk("R10 error flags persist", enterErr, 4'b0011);
    doReset();
    chk("R10 reset clears error flags", enterErr, '0);

    // sweep all non-empty masks against all early-enter patterns
    for (int m = 1; m < 16; m++) begin
      for (int e = 0; e < 16; e++) begin
        logic [N-1:0] mv, ev, expG;
        mv = m[N-1:0];
        ev = e[N-1:0];
        writeMask(mv);
        peek(ALL, g, s);
        chk("R2 R8 no stale fire before enter", s, mv);
        enter(ev);
        expG = ((ev & mv) == mv) ? ALL : ~mv;
        peek(ALL, g, s);
        chk("R3 R6 goAhead after early enters", g, expG);
        chk("R2 stall after early enters", s, ALL & ~expG);
        if ((ev & mv) != mv) begin
          enter(mv & ~ev);
          peek(ALL, g, s);
          chk("R3 R4 goAhead after last enter", g, ALL);
          chk("R4 no stall after fire", s, '0);
        end
        consumeAll();
        peek(ALL, g, s);
        chk("R5 R8 stall after consumption", s, mv);
        chk("R6 non-participant errors", enterErr, '0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule